// File: doc/BRIEF.md
# Staged Shadow Register Transfer Unit

This block holds the period value and two compare sides for a PWM-style counter, each with one or two shadow stages in front of the active register. The host writes shadow registers at any time. The active registers change only at counter event points that software selects: overflow, underflow, both, or neither. Software can then change a period or compare pair without a torn update in the middle of a counting cycle.

Each group (period, side A, side B) has its own buffering enable and its own single/double depth select. Either compare side can instead be put into capture mode. In that mode its chain runs the other way: each capture strobe loads the captured value into the active register and pushes the older values down into the shadow registers, which then act as history. All registers are registered outputs, and every response appears right after the clock edge that samples the stimulus.

Top module: `shadow_xfer_unit`

## Requirements
- R1: While `rst` is high, and after it is released, all nine registers read 0xFFFF until something changes them.
- R2: The transfer timing select `xfer_when` decides which events trigger a transfer. Code 0 means no event does. Code 1 means overflow (`ovf`) only. Code 2 means underflow (`udf`) only. Code 3 means either one.
- R3: Single depth with buffering on: a qualified event copies shadow stage 1 into the active register. Stage 2 does not change.
- R4: Double depth with buffering on: a qualified event moves all stages on the same edge. The active register takes the old stage 1 value, stage 1 takes the old stage 2 value, and stage 2 keeps its value.
- R5: The compare sides are independent chains. Side A is A (active), C (stage 1) and E (stage 2). Side B is B, D and F. Enable bit 1 and depth bit 1 control side A. Bit 2 of each controls side B. Bit 0 of each controls the period group.
- R6: When a group's buffering enable is clear, events cause no transfer and a host write to its active register lands there directly. When the enable is set, host writes to the active register are ignored.
- R7: When a host write to stage 1 and a transfer happen in the same cycle, the active register takes the old stage 1 value and stage 1 takes the written data.
- R8: In capture mode (`cap_mode` bit 0 for side A, bit 1 for side B) with buffering on and single depth, a capture strobe loads the capture data into the active register and moves the old active value into stage 1.
- R9: In capture mode with double depth, a strobe also moves the old stage 1 value into stage 2. With buffering off, a strobe only loads the active register.
- R10: A side in capture mode ignores overflow and underflow events. Its registers stay unchanged.
- R11: Host write select codes: 0 period active, 1 period stage 1, 2 period stage 2, 3 A, 4 B, 5 C, 6 D, 7 E, 8 F. A write happens on any cycle where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 4 | Host write register select |
| wr_data | input | 16 | Host write data |
| buf_en | input | 3 | Buffering enable per group (period, A side, B side) |
| dbl | input | 3 | Double-depth select per group |
| xfer_when | input | 2 | Transfer timing select |
| ovf | input | 1 | Counter overflow pulse |
| udf | input | 1 | Counter underflow pulse |
| cap_mode | input | 2 | Capture mode per compare side |
| cap_stb | input | 2 | Capture strobe per compare side |
| cap_data_a | input | 16 | Captured value for side A |
| cap_data_b | input | 16 | Captured value for side B |
| per_act | output | 16 | Active period |
| per_sh1 | output | 16 | Period stage 1 |
| per_sh2 | output | 16 | Period stage 2 |
| cmp_a | output | 16 | Side A active |
| cmp_b | output | 16 | Side B active |
| cmp_c | output | 16 | Side A stage 1 |
| cmp_d | output | 16 | Side B stage 1 |
| cmp_e | output | 16 | Side A stage 2 |
| cmp_f | output | 16 | Side B stage 2 |

## Verification
Every result is due one clock edge after its stimulus. This covers host writes, qualified events and capture strobes, because the event qualifier is combinational and feeds the register chain directly. The bench drives each stimulus on a falling edge for exactly one cycle and reads the outputs at the next falling edge, which falls half a period after the single edge that must have acted. For "no effect" cases it reads the same registers at that same falling edge and expects their earlier values.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
  localparam int unsigned DW = 16;
  localparam logic [DW-1:0] RST_VAL = '1;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned NSIDE = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PACT = 4'd0,
    SEL_PSH1 = 4'd1,
    SEL_PSH2 = 4'd2,
    SEL_A    = 4'd3,
    SEL_B    = 4'd4,
    SEL_C    = 4'd5,
    SEL_D    = 4'd6,
    SEL_E    = 4'd7,
    SEL_F    = 4'd8
  } reg_sel_e;

  typedef struct packed {
    logic act;
    logic sh1;
    logic sh2;
  } wr_hit_t;
endpackage

// File: rtl/sxu_evt_qual.sv
module sxu_evt_qual (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] when_sel,
  input  logic       ovf,
  input  logic       udf,
  output logic       xfer
);
  always_comb begin
    xfer = (when_sel[0] & ovf) | (when_sel[1] & udf);
  end

  // R2
  evt_none_chk: assert property (@(posedge clk) disable iff (rst)
    (when_sel == 2'd0) |-> !xfer);
  // R2
  evt_both_chk: assert property (@(posedge clk) disable iff (rst)
    (when_sel == 2'd3 && (ovf || udf)) |-> xfer);
endmodule

// File: rtl/sxu_chain.sv
module sxu_chain #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_act,
  input  logic         wr_sh1,
  input  logic         wr_sh2,
  input  logic [W-1:0] wr_data,
  input  logic         buf_en,
  input  logic         dbl,
  input  logic         cap_mode,
  input  logic         xfer,
  input  logic         cap_stb,
  input  logic [W-1:0] cap_data,
  output logic [W-1:0] act_q,
  output logic [W-1:0] sh1_q,
  output logic [W-1:0] sh2_q
);
  logic fwd_move;
  logic cap_move;

  always_comb begin
    fwd_move = buf_en & ~cap_mode & xfer;
    cap_move = cap_mode & cap_stb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= RST_VAL;
      sh1_q <= RST_VAL;
      sh2_q <= RST_VAL;
    end else begin
      if (fwd_move) begin
        act_q <= sh1_q;
        if (dbl) sh1_q <= sh2_q;
      end
      if (wr_act && !buf_en) act_q <= wr_data;
      if (wr_sh1) sh1_q <= wr_data;
      if (wr_sh2) sh2_q <= wr_data;
      if (cap_move) begin
        act_q <= cap_data;
        if (buf_en) begin
          sh1_q <= act_q;
          if (dbl) sh2_q <= sh1_q;
        end
      end
    end
  end

  // R3
  fwd_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_en && !cap_mode && xfer) |=> (act_q == $past(sh1_q)));
  // R4
  dbl_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_en && dbl && !cap_mode && xfer && !wr_sh1) |=> (sh1_q == $past(sh2_q)));
  // R8
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_mode && cap_stb) |=> (act_q == $past(cap_data)));
  // R10
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_act && !cap_stb && !(xfer && !cap_mode)) |=> $stable(act_q));
  // R9
  hist_push_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_mode && cap_stb && buf_en && !wr_sh1) |=> (sh1_q == $past(act_q)));
endmodule

// File: rtl/shadow_xfer_unit.sv
module shadow_xfer_unit
  import sxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic [2:0]        buf_en,
  input  logic [2:0]        dbl,
  input  logic [1:0]        xfer_when,
  input  logic              ovf,
  input  logic              udf,
  input  logic [1:0]        cap_mode,
  input  logic [1:0]        cap_stb,
  input  logic [DW-1:0]     cap_data_a,
  input  logic [DW-1:0]     cap_data_b,
  output logic [DW-1:0]     per_act,
  output logic [DW-1:0]     per_sh1,
  output logic [DW-1:0]     per_sh2,
  output logic [DW-1:0]     cmp_a,
  output logic [DW-1:0]     cmp_b,
  output logic [DW-1:0]     cmp_c,
  output logic [DW-1:0]     cmp_d,
  output logic [DW-1:0]     cmp_e,
  output logic [DW-1:0]     cmp_f
);
  logic xfer;
  wr_hit_t per_hit;
  logic [DW-1:0] side_act [NSIDE];
  logic [DW-1:0] side_sh1 [NSIDE];
  logic [DW-1:0] side_sh2 [NSIDE];
  logic [DW-1:0] side_cap [NSIDE];

  always_comb begin
    side_cap[0] = cap_data_a;
    side_cap[1] = cap_data_b;
    per_hit.act = wr_en && (wr_sel == SEL_PACT);
    per_hit.sh1 = wr_en && (wr_sel == SEL_PSH1);
    per_hit.sh2 = wr_en && (wr_sel == SEL_PSH2);
  end

  sxu_evt_qual u_qual (
    .clk      (clk),
    .rst      (rst),
    .when_sel (xfer_when),
    .ovf      (ovf),
    .udf      (udf),
    .xfer     (xfer)
  );

  sxu_chain #(.W(DW), .RST_VAL(RST_VAL)) u_period (
    .clk      (clk),
    .rst      (rst),
    .wr_act   (per_hit.act),
    .wr_sh1   (per_hit.sh1),
    .wr_sh2   (per_hit.sh2),
    .wr_data  (wr_data),
    .buf_en   (buf_en[0]),
    .dbl      (dbl[0]),
    .cap_mode (1'b0),
    .xfer     (xfer),
    .cap_stb  (1'b0),
    .cap_data ({DW{1'b0}}),
    .act_q    (per_act),
    .sh1_q    (per_sh1),
    .sh2_q    (per_sh2)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam logic [SEL_W-1:0] ACT_CODE = SEL_A + SEL_W'(s);
    localparam logic [SEL_W-1:0] SH1_CODE = SEL_C + SEL_W'(s);
    localparam logic [SEL_W-1:0] SH2_CODE = SEL_E + SEL_W'(s);
    wr_hit_t hit;

    always_comb begin
      hit.act = wr_en && (wr_sel == ACT_CODE);
      hit.sh1 = wr_en && (wr_sel == SH1_CODE);
      hit.sh2 = wr_en && (wr_sel == SH2_CODE);
    end

    sxu_chain #(.W(DW), .RST_VAL(RST_VAL)) u_side (
      .clk      (clk),
      .rst      (rst),
      .wr_act   (hit.act),
      .wr_sh1   (hit.sh1),
      .wr_sh2   (hit.sh2),
      .wr_data  (wr_data),
      .buf_en   (buf_en[s+1]),
      .dbl      (dbl[s+1]),
      .cap_mode (cap_mode[s]),
      .xfer     (xfer),
      .cap_stb  (cap_stb[s]),
      .cap_data (side_cap[s]),
      .act_q    (side_act[s]),
      .sh1_q    (side_sh1[s]),
      .sh2_q    (side_sh2[s])
    );
  end

  always_comb begin
    cmp_a = side_act[0];
    cmp_b = side_act[1];
    cmp_c = side_sh1[0];
    cmp_d = side_sh1[1];
    cmp_e = side_sh2[0];
    cmp_f = side_sh2[1];
  end

  // R1
  rst_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (per_act == RST_VAL && cmp_a == RST_VAL && cmp_f == RST_VAL));
endmodule

// File: tb/tb_shadow_xfer_unit.sv
module tb_shadow_xfer_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  buf_en = '0;
  logic [2:0]  dbl = '0;
  logic [1:0]  xfer_when = '0;
  logic        ovf = 1'b0;
  logic        udf = 1'b0;
  logic [1:0]  cap_mode = '0;
  logic [1:0]  cap_stb = '0;
  logic [15:0] cap_data_a = '0;
  logic [15:0] cap_data_b = '0;
  logic [15:0] per_act, per_sh1, per_sh2;
  logic [15:0] cmp_a, cmp_b, cmp_c, cmp_d, cmp_e, cmp_f;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shadow_xfer_unit dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .buf_en(buf_en), .dbl(dbl), .xfer_when(xfer_when), .ovf(ovf), .udf(udf),
    .cap_mode(cap_mode), .cap_stb(cap_stb), .cap_data_a(cap_data_a),
    .cap_data_b(cap_data_b), .per_act(per_act), .per_sh1(per_sh1),
    .per_sh2(per_sh2), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
    .cmp_d(cmp_d), .cmp_e(cmp_e), .cmp_f(cmp_f)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic hwrite(input logic [3:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic evt(input logic o, input logic u);
    ovf = o; udf = u;
    @(negedge clk);
    ovf = 1'b0; udf = 1'b0;
  endtask

  task automatic cap_a(input logic [15:0] d);
    cap_stb = 2'b01; cap_data_a = d;
    @(negedge clk);
    cap_stb = 2'b00;
  endtask

  task automatic t_reset;
    chk("R1 per_act", per_act, 16'hFFFF);
    chk("R1 per_sh1", per_sh1, 16'hFFFF);
    chk("R1 per_sh2", per_sh2, 16'hFFFF);
    chk("R1 cmp_a", cmp_a, 16'hFFFF);
    chk("R1 cmp_b", cmp_b, 16'hFFFF);
    chk("R1 cmp_c", cmp_c, 16'hFFFF);
    chk("R1 cmp_d", cmp_d, 16'hFFFF);
    chk("R1 cmp_e", cmp_e, 16'hFFFF);
    chk("R1 cmp_f", cmp_f, 16'hFFFF);
  endtask

  task automatic t_timing;
    buf_en = 3'b001; dbl = 3'b000;
    hwrite(4'd1, 16'h1111);
    xfer_when = 2'd0;
    evt(1'b1, 1'b1);
    chk("R2 code0 none", per_act, 16'hFFFF);
    xfer_when = 2'd1;
    evt(1'b0, 1'b1);
    chk("R2 code1 udf ignored", per_act, 16'hFFFF);
    evt(1'b1, 1'b0);
    chk("R2 code1 ovf R3", per_act, 16'h1111);
    chk("R3 sh2 untouched", per_sh2, 16'hFFFF);
    hwrite(4'd1, 16'h2222);
    xfer_when = 2'd2;
    evt(1'b1, 1'b0);
    chk("R2 code2 ovf ignored", per_act, 16'h1111);
    evt(1'b0, 1'b1);
    chk("R2 code2 udf", per_act, 16'h2222);
    xfer_when = 2'd3;
    hwrite(4'd1, 16'h3333);
    evt(1'b1, 1'b0);
    chk("R2 code3 ovf", per_act, 16'h3333);
    hwrite(4'd1, 16'h4444);
    evt(1'b0, 1'b1);
    chk("R2 code3 udf", per_act, 16'h4444);
  endtask

  task automatic t_double;
    buf_en[0] = 1'b1; dbl[0] = 1'b1; xfer_when = 2'd3;
    hwrite(4'd1, 16'h0A0A);
    hwrite(4'd2, 16'h0B0B);
    evt(1'b1, 1'b0);
    chk("R4 act old sh1", per_act, 16'h0A0A);
    chk("R4 sh1 old sh2", per_sh1, 16'h0B0B);
    chk("R4 sh2 kept", per_sh2, 16'h0B0B);
    evt(1'b0, 1'b1);
    chk("R4 second step", per_act, 16'h0B0B);
  endtask

  task automatic t_sides;
    buf_en = 3'b110; dbl = 3'b010; xfer_when = 2'd3; cap_mode = 2'b00;
    hwrite(4'd5, 16'h00C0);
    hwrite(4'd7, 16'h00E0);
    hwrite(4'd6, 16'h00D0);
    hwrite(4'd8, 16'h00F0);
    evt(1'b1, 1'b0);
    chk("R5 A from C", cmp_a, 16'h00C0);
    chk("R5 C from E", cmp_c, 16'h00E0);
    chk("R5 E kept", cmp_e, 16'h00E0);
    chk("R5 B from D", cmp_b, 16'h00D0);
    chk("R5 D single kept", cmp_d, 16'h00D0);
    chk("R5 F kept", cmp_f, 16'h00F0);
  endtask

  task automatic t_enable;
    buf_en = 3'b000; dbl = 3'b000; xfer_when = 2'd3;
    hwrite(4'd0, 16'h6789);
    chk("R6 direct write", per_act, 16'h6789);
    hwrite(4'd1, 16'h5555);
    chk("R11 sel1 sh1", per_sh1, 16'h5555);
    evt(1'b1, 1'b1);
    chk("R6 no transfer when off", per_act, 16'h6789);
    buf_en = 3'b001;
    hwrite(4'd0, 16'h1234);
    chk("R6 act write ignored", per_act, 16'h6789);
  endtask

  task automatic t_collide;
    buf_en = 3'b001; dbl = 3'b000; xfer_when = 2'd1;
    wr_en = 1'b1; wr_sel = 4'd1; wr_data = 16'h7777; ovf = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ovf = 1'b0;
    chk("R7 act old shadow", per_act, 16'h5555);
    chk("R7 shadow new data", per_sh1, 16'h7777);
  endtask

  task automatic t_capture;
    cap_mode = 2'b00; buf_en = 3'b000; dbl = 3'b000;
    hwrite(4'd3, 16'h0001);
    hwrite(4'd5, 16'h0002);
    hwrite(4'd7, 16'h0003);
    chk("R11 sel3 A", cmp_a, 16'h0001);
    cap_mode = 2'b01; buf_en = 3'b010;
    cap_a(16'h1357);
    chk("R8 A captured", cmp_a, 16'h1357);
    chk("R8 C old A", cmp_c, 16'h0001);
    chk("R8 E kept single", cmp_e, 16'h0003);
    dbl = 3'b010;
    cap_a(16'h2468);
    chk("R9 A captured", cmp_a, 16'h2468);
    chk("R9 C old A", cmp_c, 16'h1357);
    chk("R9 E old C", cmp_e, 16'h0001);
    xfer_when = 2'd3;
    evt(1'b1, 1'b1);
    chk("R10 A kept", cmp_a, 16'h2468);
    chk("R10 C kept", cmp_c, 16'h1357);
    buf_en = 3'b000;
    cap_a(16'h9999);
    chk("R9 unbuffered A", cmp_a, 16'h9999);
    chk("R9 unbuffered C kept", cmp_c, 16'h1357);
    cap_mode = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timing();
    t_double();
    t_sides();
    t_enable();
    t_collide();
    t_capture();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule